// File: doc/BRIEF.md
# Bus-Master Disk DMA Control and Status Registers

This block is the register front end of a bus-mastering disk DMA engine. Software reaches it through a single read/write register port and uses it to program the base address of the descriptor table, to pick the transfer direction and to start or stop the engine. The datapath reports three things back: the engine has stopped at the end of the table, an error occurred, or an interrupt event arrived. The block keeps these as status bits and drives an interrupt line.

The status register holds three kinds of bit. One bit is a live activity indication that only the hardware can change. Two bits are sticky event flags that software clears by writing a one. The remaining bits are plain storage. Two of these storage bits tell software which of the two attached drives may use DMA. Because of this mix, the usual way to clear the event flags is a read-modify-write: read the register, force both flag positions to one, and write the value back. This clears the flags and leaves the storage bits as they were.

Two combinational side outputs help at the end of a transfer. The first is a pass/fail verdict on the three low status bits, with a failure code. The second is a busy hint that a timeout handler can sample.

Top module: `dmactl_regfile`

## Requirements
- R1: After reset, all three registers read zero, and eng_start, eng_to_mem, irq_out and busy_hint are low.
- R2: Register address 0 is the command register. Bit 0 is start, which drives eng_start. Bit 3 is direction, which drives eng_to_mem: 1 means device to memory and 0 means memory to device. All other bits read 0.
- R3: Status bit 0 (active) becomes 1 one cycle after a command write that changes start from 0 to 1.
- R4: The active bit goes to 0 after a dp_done pulse, after a dp_err pulse, or after a command write that clears start. Rewriting start=1 while start is already 1 does not set the active bit again. If a rising start and a clear event happen in the same cycle, the rising start wins.
- R5: Status bit 1 (error) is set by dp_err and status bit 2 (interrupt) is set by dp_irq. Both bits hold their value until a status write (address 1) has a 1 at their position. Writing 0 at their position leaves them unchanged. If a set and a clear happen in the same cycle, the set wins.
- R6: Status bits 3 to 6 are plain read/write storage. Bit 7 always reads 0. Bit 0 cannot be changed by a write.
- R7: Status bits 5 and 6 are the capability flags for drive 0 and drive 1. Read-modify-writing one of them, with bits 1 and 2 forced to 1, clears both event flags and keeps the other storage bits.
- R8: irq_out is 1 exactly in the cycles in which the interrupt flag reads 1.
- R9: Address 2 is a 32-bit read/write register for the descriptor table base, and it drives tbl_base. Address 3 reads 0, and writes to address 3 have no effect.
- R10: xfer_good is 1 exactly when status bits [2:0] equal 3'b100. When xfer_good is 1, xfer_code is 0. Otherwise xfer_code is the status byte OR 0x10.
- R11: busy_hint is 1 exactly when status bits 3 and 4 are both 1.
- R12: A write (bus_wr=1) while bus_sel=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid when bus_sel is 1 |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_start | output | 1 | Start control to the datapath |
| eng_to_mem | output | 1 | Direction control, 1 = device to memory |
| dp_done | input | 1 | Datapath reached the end of the descriptor table |
| dp_err | input | 1 | Datapath error event |
| dp_irq | input | 1 | Interrupt event |
| irq_out | output | 1 | Interrupt request line |
| tbl_base | output | 32 | Descriptor table base address |
| xfer_good | output | 1 | Transfer verdict: success |
| xfer_code | output | 8 | Failure code (0 on success) |
| busy_hint | output | 1 | Status bits 3 and 4 are both set |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a write-one-to-clear of a flag landing in the same cycle as the hardware event that sets that flag. The other is a start edge landing together with an end-of-table or error pulse. Directed steps line up such a status write or command write with a datapath pulse in one cycle. A long random phase then mixes bus writes with sparse datapath pulses, while a behavioural model checks every output on every clock. The read-modify-write sequence on the drive capability bits is run with both event flags set, so that it shows the flags clearing and the storage bits surviving in a single write.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
    localparam int ADDR_W  = 2;
    localparam int REG_W   = 8;

    localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_TBL  = 2'd2;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 3;

    localparam int SB_ACT   = 0;
    localparam int SB_ERR   = 1;
    localparam int SB_INT   = 2;
    localparam int SB_RW_LO = 3;
    localparam int SB_RW_HI = 6;
    localparam int RW_W     = SB_RW_HI - SB_RW_LO + 1;

    localparam logic [REG_W-1:0] FAIL_MARK = 8'h10;

    typedef struct packed {
        logic start;
        logic to_mem;
    } cmd_t;

    typedef struct packed {
        logic [RW_W-1:0] rw;
        logic            intr;
        logic            err;
        logic            act;
    } stat_t;
endpackage

// File: rtl/dmactl_cmd.sv
module dmactl_cmd
    import dmactl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic [REG_W-1:0] wdata,
    output logic             start,
    output logic             to_mem,
    output logic             start_rise,
    output logic             start_fall
);
    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d      = cmd_q;
        start_rise = 1'b0;
        start_fall = 1'b0;
        if (wr_cmd) begin
            cmd_d.start  = wdata[CB_START];
            cmd_d.to_mem = wdata[CB_DIR];
            start_rise   = wdata[CB_START] && !cmd_q.start;
            start_fall   = !wdata[CB_START] && cmd_q.start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign start  = cmd_q.start;
    assign to_mem = cmd_q.to_mem;
endmodule

// File: rtl/dmactl_status.sv
module dmactl_status
    import dmactl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [REG_W-1:0] wdata,
    input  logic             start_rise,
    input  logic             start_fall,
    input  logic             dp_done,
    input  logic             dp_err,
    input  logic             dp_irq,
    output logic [REG_W-1:0] stat_byte
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // live activity bit: start edge has priority over stop causes
        if (start_rise)
            st_d.act = 1'b1;
        else if (dp_done || dp_err || start_fall)
            st_d.act = 1'b0;

        // sticky events, write-one-to-clear, set dominates
        if (dp_err)
            st_d.err = 1'b1;
        else if (wr_stat && wdata[SB_ERR])
            st_d.err = 1'b0;

        if (dp_irq)
            st_d.intr = 1'b1;
        else if (wr_stat && wdata[SB_INT])
            st_d.intr = 1'b0;

        if (wr_stat)
            st_d.rw = wdata[SB_RW_HI:SB_RW_LO];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_byte = {1'b0, st_q};
endmodule

// File: rtl/dmactl_ptr.sv
module dmactl_ptr #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ptr,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] base
);
    logic [PTR_W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (wr_ptr) base_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base = base_q;
endmodule

// File: rtl/dmactl_verdict.sv
module dmactl_verdict
    import dmactl_pkg::*;
(
    input  logic [REG_W-1:0] stat_byte,
    output logic             good,
    output logic [REG_W-1:0] code,
    output logic             busy
);
    localparam logic [2:0] GOOD_PAT = 3'b100;

    always_comb begin
        good = (stat_byte[SB_INT:SB_ACT] == GOOD_PAT);
        code = good ? '0 : (stat_byte | FAIL_MARK);
        busy = stat_byte[4] && stat_byte[3];
    end
endmodule

// File: rtl/dmactl_regfile.sv
module dmactl_regfile
    import dmactl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_start,
    output logic              eng_to_mem,
    input  logic              dp_done,
    input  logic              dp_err,
    input  logic              dp_irq,
    output logic              irq_out,
    output logic [DATA_W-1:0] tbl_base,
    output logic              xfer_good,
    output logic [REG_W-1:0]  xfer_code,
    output logic              busy_hint
);
    logic             wr_any, wr_cmd, wr_stat, wr_tbl;
    logic             start_rise, start_fall;
    logic [REG_W-1:0] stat_byte;

    assign wr_any  = bus_sel && bus_wr;
    assign wr_cmd  = wr_any && (bus_addr == A_CMD);
    assign wr_stat = wr_any && (bus_addr == A_STAT);
    assign wr_tbl  = wr_any && (bus_addr == A_TBL);

    dmactl_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .wdata      (bus_wdata[REG_W-1:0]),
        .start      (eng_start),
        .to_mem     (eng_to_mem),
        .start_rise (start_rise),
        .start_fall (start_fall)
    );

    dmactl_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_stat),
        .wdata      (bus_wdata[REG_W-1:0]),
        .start_rise (start_rise),
        .start_fall (start_fall),
        .dp_done    (dp_done),
        .dp_err     (dp_err),
        .dp_irq     (dp_irq),
        .stat_byte  (stat_byte)
    );

    dmactl_ptr #(.PTR_W(DATA_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ptr (wr_tbl),
        .wdata  (bus_wdata),
        .base   (tbl_base)
    );

    dmactl_verdict u_verdict (
        .stat_byte (stat_byte),
        .good      (xfer_good),
        .code      (xfer_code),
        .busy      (busy_hint)
    );

    assign irq_out = stat_byte[SB_INT];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CMD: begin
                bus_rdata[CB_START] = eng_start;
                bus_rdata[CB_DIR]   = eng_to_mem;
            end
            A_STAT:  bus_rdata[REG_W-1:0] = stat_byte;
            A_TBL:   bus_rdata = tbl_base;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmactl_regfile_chk.sv
module dmactl_regfile_chk
    import dmactl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              eng_start,
    input logic              dp_done,
    input logic              dp_err,
    input logic              dp_irq,
    input logic              irq_out,
    input logic [31:0]       tbl_base,
    input logic              xfer_good,
    input logic [REG_W-1:0]  stat_byte
);
    logic rise_now, clr_int_now;
    assign rise_now    = bus_sel && bus_wr && bus_addr == A_CMD && bus_wdata[0] && !eng_start;
    assign clr_int_now = bus_sel && bus_wr && bus_addr == A_STAT && bus_wdata[2];

    p_act_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_start) |-> stat_byte[0]);
    p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_start) |-> !stat_byte[0]);
    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_done && !rise_now) |=> !stat_byte[0]);
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dp_err |=> stat_byte[1]);
    p_int_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dp_irq |=> irq_out);
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !clr_int_now) |=> irq_out);
    p_good_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_good |-> (irq_out && !eng_start) || (irq_out && !stat_byte[0]));
    p_ptr_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(tbl_base));
endmodule

bind dmactl_regfile dmactl_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .eng_start (eng_start),
    .dp_done   (dp_done),
    .dp_err    (dp_err),
    .dp_irq    (dp_irq),
    .irq_out   (irq_out),
    .tbl_base  (tbl_base),
    .xfer_good (xfer_good),
    .stat_byte (stat_byte)
);

// File: tb/dmactl_regfile_tb_top.sv
module dmactl_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start, eng_to_mem, irq_out, xfer_good, busy_hint;
    logic [31:0] tbl_base;
    logic [7:0]  xfer_code;
    logic        dp_done = 1'b0, dp_err = 1'b0, dp_irq = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dmactl_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_to_mem(eng_to_mem),
        .dp_done(dp_done), .dp_err(dp_err), .dp_irq(dp_irq),
        .irq_out(irq_out), .tbl_base(tbl_base), .xfer_good(xfer_good),
        .xfer_code(xfer_code), .busy_hint(busy_hint)
    );

    // behavioural reference
    bit        m_start, m_dir, m_act, m_err, m_int;
    bit [3:0]  m_rw;
    bit [31:0] m_ptr;

    function automatic bit [7:0] m_stat();
        return {1'b0, m_rw, m_int, m_err, m_act};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_dir = 0; m_act = 0; m_err = 0; m_int = 0;
            m_rw = 0; m_ptr = 0;
        end else begin
            bit w, rise, fall;
            w = bus_sel && bus_wr;
            rise = w && bus_addr == 0 && bus_wdata[0] && !m_start;
            fall = w && bus_addr == 0 && !bus_wdata[0] && m_start;
            if (rise) m_act = 1;
            else if (dp_done || dp_err || fall) m_act = 0;
            if (dp_err) m_err = 1;
            else if (w && bus_addr == 1 && bus_wdata[1]) m_err = 0;
            if (dp_irq) m_int = 1;
            else if (w && bus_addr == 1 && bus_wdata[2]) m_int = 0;
            if (w && bus_addr == 1) m_rw = bus_wdata[6:3];
            if (w && bus_addr == 0) begin
                m_start = bus_wdata[0];
                m_dir   = bus_wdata[3];
            end
            if (w && bus_addr == 2) m_ptr = bus_wdata;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] exp_rd;
            bit [7:0] s;
            bit good;
            s = m_stat();
            good = (s[2:0] == 3'b100);
            case (bus_addr)
                2'd0: exp_rd = {28'd0, m_dir, 2'b00, m_start};
                2'd1: exp_rd = {24'd0, s};
                2'd2: exp_rd = m_ptr;
                default: exp_rd = 32'd0;
            endcase
            check(bus_rdata === exp_rd, "R2/R6/R9 rdata", bus_rdata, exp_rd);
            check(eng_start === m_start, "R2 eng_start", 32'(eng_start), 32'(m_start));
            check(eng_to_mem === m_dir, "R2 eng_to_mem", 32'(eng_to_mem), 32'(m_dir));
            check(irq_out === m_int, "R8 irq_out", 32'(irq_out), 32'(m_int));
            check(tbl_base === m_ptr, "R9 tbl_base", tbl_base, m_ptr);
            check(xfer_good === good, "R10 xfer_good", 32'(xfer_good), 32'(good));
            check(xfer_code === (good ? 8'h00 : (s | 8'h10)), "R10 xfer_code",
                  32'(xfer_code), 32'(good ? 8'h00 : (s | 8'h10)));
            check(busy_hint === (s[3] && s[4]), "R11 busy_hint",
                  32'(busy_hint), 32'(s[3] && s[4]));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse(input bit dn, input bit er, input bit iq);
        dp_done = dn; dp_err = er; dp_irq = iq;
        tick();
        dp_done = 0; dp_err = 0; dp_irq = 0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1; tick();

        // R1 reset state
        rd(0, v); check(v == 0, "R1 cmd reset", v, 0);
        rd(1, v); check(v == 0, "R1 stat reset", v, 0);
        rd(2, v); check(v == 0, "R1 ptr reset", v, 0);
        check(!irq_out && !eng_start && !busy_hint, "R1 outputs reset", 32'(irq_out), 0);

        // R2 R3 start with direction
        wr(0, 32'hFFFF_FF09);
        rd(0, v); check(v == 32'h9, "R2 cmd readback", v, 32'h9);
        rd(1, v); check(v[0] == 1, "R3 active after start", v, 1);
        check(eng_to_mem == 1, "R2 direction", 32'(eng_to_mem), 1);

        // R4 done clears, rewrite does not re-set
        pulse(1, 0, 0);
        rd(1, v); check(v[0] == 0, "R4 done clears active", v, 0);
        wr(0, 32'h9);
        rd(1, v); check(v[0] == 0, "R4 rewrite no re-arm", v, 0);
        wr(0, 32'h8); wr(0, 32'h9);
        rd(1, v); check(v[0] == 1, "R4 re-arm after stop", v, 1);
        pulse(0, 1, 0);
        rd(1, v); check(v[1:0] == 2'b10, "R4 R5 err clears active sets err", v, 2);
        wr(0, 32'h8); wr(0, 32'h1);
        wr(0, 32'h0);
        rd(1, v); check(v[0] == 0, "R4 stop clears active", v, 0);

        // R5 R8 R10 interrupt flag, verdict
        wr(1, 32'h2);
        pulse(0, 0, 1);
        rd(1, v); check(v[2:0] == 3'b100, "R5 intr sticky", v, 4);
        check(irq_out == 1, "R8 irq asserted", 32'(irq_out), 1);
        check(xfer_good == 1 && xfer_code == 0, "R10 good verdict", 32'(xfer_code), 0);
        pulse(0, 1, 0);
        check(xfer_good == 0 && xfer_code == 8'h16, "R10 fail code", 32'(xfer_code), 32'h16);
        wr(1, 32'h0);
        rd(1, v); check(v[2:1] == 2'b11, "R5 write zero keeps flags", v, 6);

        // R7 capability bits via read-modify-write
        wr(1, 32'h20);
        rd(1, v); check(v == 32'h26, "R7 cap0 set flags kept", v, 32'h26);
        wr(1, v | 32'h46);
        rd(1, v); check(v == 32'h60, "R7 rmw clears flags keeps caps", v, 32'h60);
        check(irq_out == 0, "R8 irq dropped", 32'(irq_out), 0);

        // R5 set wins over clear in the same cycle
        bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h66; dp_irq = 1;
        tick();
        bus_sel = 0; bus_wr = 0; dp_irq = 0;
        rd(1, v); check(v[2] == 1, "R5 set beats clear", v, 4);

        // R6 R11 plain bits, bit7, bit0
        wr(1, 32'h9E);
        rd(1, v); check(v == 32'h18, "R6 bit7 and bit0 not writable", v, 32'h18);
        check(busy_hint == 1, "R11 busy with 3 and 4", 32'(busy_hint), 1);
        wr(1, 32'h08);
        check(busy_hint == 0, "R11 busy off", 32'(busy_hint), 0);

        // R9 table pointer, address 3
        wr(2, 32'hDEAD_BEE4);
        rd(2, v); check(v == 32'hDEAD_BEE4, "R9 ptr readback", v, 32'hDEAD_BEE4);
        wr(3, 32'hFFFF_FFFF);
        rd(3, v); check(v == 0, "R9 addr3 reads zero", v, 0);
        rd(2, v); check(v == 32'hDEAD_BEE4, "R9 addr3 write ignored", v, 32'hDEAD_BEE4);

        // R12 write without select
        bus_sel = 0; bus_wr = 1; bus_addr = 2; bus_wdata = 32'h1234_5678;
        tick();
        bus_wr = 0;
        rd(2, v); check(v == 32'hDEAD_BEE4, "R12 unselected write ignored", v, 32'hDEAD_BEE4);

        // random phase, per-cycle comparison against the model
        for (int i = 0; i < 2000; i++) begin
            bus_sel   = ($urandom_range(0, 2) != 0);
            bus_wr    = $urandom_range(0, 1);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = $urandom;
            dp_done   = ($urandom_range(0, 9) == 0);
            dp_err    = ($urandom_range(0, 19) == 0);
            dp_irq    = ($urandom_range(0, 9) == 0);
            tick();
        end
        bus_sel = 0; bus_wr = 0; dp_done = 0; dp_err = 0; dp_irq = 0;
        tick(); tick();

        finished = 1;
        summary();
        $finish;
    end
endmodule